// File: doc/BRIEF.md
# Dual-Port Collision Busy Arbiter

This block sits beside a storage array that two independent ports can reach at once. In every cycle it compares the enable and address of the left port with those of the right port. When both are enabled at the same location, it lets one port carry on and pulls the other port's active-low busy flag low. It also produces a per-port write enable that the array uses directly. A port that is flagged busy can never write, so the array cannot be modified from the losing side. The decision looks only at enables and addresses. Whether either access is a read or a write plays no part in it.

A mode input sets how the busy pins behave. In master mode (mode high) the block arbitrates and drives the busy outputs. In slave mode (mode low) it does not arbitrate. The busy inputs then act only as write inhibits for their ports, and the busy outputs stay at their inactive high level. Several slices placed side by side for a wider word can therefore follow one master's decision. Because busy is active low, the busy flags of banks stacked in depth are combined with an AND gate.

Winner selection works as follows. When both ports arrive at one address in the same cycle, the left port wins. When one port was already at that address without being blocked in the previous cycle, that port keeps the location until it moves or drops its enable. Busy is decoded in the same cycle as the collision, so the write gating never sees a late inhibit.

Top module: `dpa_busy_arbiter`

## Requirements
- R1: In master mode, when the ports are not both enabled or their addresses differ, both busy outputs are high.
- R2: In master mode, when both ports are enabled at the same address and neither held that address unblocked in the previous cycle, the left busy output is high and the right busy output is low.
- R3: The two busy outputs are never low at the same time.
- R4: In master mode, if a port was enabled and not blocked at an address in the previous cycle and the other port now collides with it at that same address, the incumbent port keeps its busy output high and the newcomer's busy output goes low.
- R5: Each write enable output equals that port's enable AND its write request AND NOT its effective busy. In master mode, effective busy is the arbiter's decision.
- R6: The read/write requests of both ports have no effect on which busy output is asserted.
- R7: Busy outputs are combinational on the current enables and addresses and are valid in the same cycle the collision appears.
- R8: In slave mode, both busy outputs are held high, and each port's effective busy is the inverse of its busy input. A low busy input blocks every write from that port, and a high busy input lets writes through.
- R9: Reset clears all record of which port held a location, so the first collision after reset is resolved as a simultaneous arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1 = arbitrate and drive busy, 0 = busy inputs act as write inhibits |
| l_en | input | 1 | Left port enable |
| l_addr | input | ADDR_W | Left port address |
| l_wr_req | input | 1 | Left port write request |
| l_busy_n_in | input | 1 | Left write inhibit in slave mode, active low |
| r_en | input | 1 | Right port enable |
| r_addr | input | ADDR_W | Right port address |
| r_wr_req | input | 1 | Right port write request |
| r_busy_n_in | input | 1 | Right write inhibit in slave mode, active low |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_busy_n | output | 1 | Right busy flag, active low |
| l_wr_en | output | 1 | Gated write enable to the array, left |
| r_wr_en | output | 1 | Gated write enable to the array, right |

## Verification
The bench runs the arbiter with a 3-bit address and sweeps every combination of enables, both addresses, both write requests and, in slave mode, both busy inputs. Because the loops hold the addresses steady across the inner write-request loop, incumbency cases arise naturally. The bench targets the following faults, each against a cycle model of its own:
- A design that breaks simultaneous ties toward the right, or that forgets incumbency, would flag the wrong port in cycles where the model expects the other.
- A design that lets read/write into the decision would report different busy values in the paired directed runs.
- A design that gates writes with the raw busy input in master mode, or that keeps arbitrating in slave mode, would show write enables or busy outputs that disagree with the model.
- A design that keeps its holder record through reset would hand the first post-reset collision to the port that was active during reset.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  typedef enum logic {
    WIN_LEFT  = 1'b0,
    WIN_RIGHT = 1'b1
  } win_e;

  // Right wins only when it alone already held the location.
  function automatic win_e pick_winner(input logic left_holds, input logic right_holds);
    if (right_holds && !left_holds) return WIN_RIGHT;
    return WIN_LEFT;
  endfunction

  function automatic logic gate_write(input logic en, input logic wr_req, input logic busy);
    return en & wr_req & ~busy;
  endfunction

endpackage

// File: rtl/dpa_collide.sv
module dpa_collide #(
  parameter int ADDR_W = 13
) (
  input  logic              a_en,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              b_en,
  input  logic [ADDR_W-1:0] b_addr,
  output logic              collide
);

  logic same_addr;

  assign same_addr = (a_addr == b_addr);
  assign collide   = a_en & b_en & same_addr;

endmodule

// File: rtl/dpa_incumbent.sv
module dpa_incumbent #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output logic              holds
);

  logic              held_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      addr_q <= '0;
    end else begin
      held_q <= en & ~busy;
      addr_q <= addr;
    end
  end

  // The port continues an unblocked access at the same address.
  assign holds = held_q & (addr_q == addr);

  AST_HOLD_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !holds) else $error("holder survived reset"); // R9

endmodule

// File: rtl/dpa_wr_gate.sv
module dpa_wr_gate
  import dpa_pkg::*;
(
  input  logic en,
  input  logic wr_req,
  input  logic busy,
  output logic wr_en
);

  assign wr_en = gate_write(en, wr_req, busy);

endmodule

// File: rtl/dpa_busy_arbiter.sv
module dpa_busy_arbiter
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr_req,
  input  logic              l_busy_n_in,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr_req,
  input  logic              r_busy_n_in,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_wr_en,
  output logic              r_wr_en
);

  localparam int NPORT = 2;
  localparam int LEFT  = 0;
  localparam int RIGHT = 1;

  logic [NPORT-1:0]  en_v;
  logic [NPORT-1:0]  wr_req_v;
  logic [NPORT-1:0]  busy_in_n_v;
  logic [NPORT-1:0]  holds_v;
  logic [NPORT-1:0]  arb_busy_v;
  logic [NPORT-1:0]  busy_eff_v;
  logic [NPORT-1:0]  wr_en_v;
  logic [ADDR_W-1:0] addr_v [NPORT];

  logic collide;
  logic fresh_clash;
  logic kept_clash;
  win_e winner;

  assign en_v        = {r_en, l_en};
  assign wr_req_v    = {r_wr_req, l_wr_req};
  assign busy_in_n_v = {r_busy_n_in, l_busy_n_in};
  assign addr_v[LEFT]  = l_addr;
  assign addr_v[RIGHT] = r_addr;

  dpa_collide #(.ADDR_W(ADDR_W)) u_collide (
    .a_en    (l_en),
    .a_addr  (l_addr),
    .b_en    (r_en),
    .b_addr  (r_addr),
    .collide (collide)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpa_incumbent #(.ADDR_W(ADDR_W)) u_inc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_v[p]),
      .addr  (addr_v[p]),
      .busy  (busy_eff_v[p]),
      .holds (holds_v[p])
    );

    dpa_wr_gate u_gate (
      .en     (en_v[p]),
      .wr_req (wr_req_v[p]),
      .busy   (busy_eff_v[p]),
      .wr_en  (wr_en_v[p])
    );
  end

  assign winner      = pick_winner(holds_v[LEFT], holds_v[RIGHT]);
  assign fresh_clash = collide & ~|holds_v;
  assign kept_clash  = collide & |holds_v;

  assign arb_busy_v[LEFT]  = master_mode & collide & (winner == WIN_RIGHT);
  assign arb_busy_v[RIGHT] = master_mode & collide & (winner == WIN_LEFT);

  assign busy_eff_v = master_mode ? arb_busy_v : ~busy_in_n_v;

  assign l_busy_n = master_mode ? ~arb_busy_v[LEFT]  : 1'b1;
  assign r_busy_n = master_mode ? ~arb_busy_v[RIGHT] : 1'b1;
  assign l_wr_en  = wr_en_v[LEFT];
  assign r_wr_en  = wr_en_v[RIGHT];

  AST_NO_FALSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode && !collide |-> l_busy_n && r_busy_n) else $error("busy without clash"); // R1

  AST_FRESH_LEFT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode && fresh_clash |-> l_busy_n && !r_busy_n) else $error("tie not to left"); // R2

  AST_ONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    l_busy_n || r_busy_n) else $error("both ports busy"); // R3

  AST_RIGHT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(master_mode && r_en && r_busy_n) && master_mode && collide
    && (r_addr == $past(r_addr)) |-> r_busy_n && !l_busy_n) else $error("incumbent lost"); // R4

  AST_KEPT_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode && kept_clash |-> (l_busy_n != r_busy_n)) else $error("kept clash unflagged"); // R4

  AST_WR_BLOCK_L: assert property (@(posedge clk) disable iff (!rst_n)
    !l_busy_n |-> !l_wr_en) else $error("left write while busy"); // R5

  AST_WR_BLOCK_R: assert property (@(posedge clk) disable iff (!rst_n)
    !r_busy_n |-> !r_wr_en) else $error("right write while busy"); // R5

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> l_busy_n && r_busy_n) else $error("slave drove busy"); // R8

  AST_SLAVE_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode && (!l_busy_n_in || !r_busy_n_in) |->
    (l_busy_n_in || !l_wr_en) && (r_busy_n_in || !r_wr_en)) else $error("inhibit ignored"); // R8

endmodule

// File: tb/dpa_busy_arbiter_bench.sv
module dpa_busy_arbiter_bench;

  localparam int AW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, master_mode;
  logic          l_en, l_wr_req, l_busy_n_in, r_en, r_wr_req, r_busy_n_in;
  logic [AW-1:0] l_addr, r_addr;
  logic          l_busy_n, r_busy_n, l_wr_en, r_wr_en;

  dpa_busy_arbiter #(.ADDR_W(AW)) u_dpa_busy_arbiter (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_en(l_en), .l_addr(l_addr), .l_wr_req(l_wr_req), .l_busy_n_in(l_busy_n_in),
    .r_en(r_en), .r_addr(r_addr), .r_wr_req(r_wr_req), .r_busy_n_in(r_busy_n_in),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n), .l_wr_en(l_wr_en), .r_wr_en(r_wr_en)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  // Bench's own record of unblocked holders.
  bit            m_lv, m_rv;
  logic [AW-1:0] m_la, m_ra;

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // obs = {l_busy_n, r_busy_n, l_wr_en, r_wr_en}
  task automatic step(input bit ms, input bit le, input int la, input bit lw, input bit lbi,
                      input bit re, input int ra, input bit rw, input bit rbi,
                      output logic [3:0] obs);
    bit coll, lc, rc, lwin, bl, br, ebl, ebr;
    string tag;
    @(negedge clk);
    master_mode = ms;
    l_en = le; l_addr = AW'(la); l_wr_req = lw; l_busy_n_in = lbi;
    r_en = re; r_addr = AW'(ra); r_wr_req = rw; r_busy_n_in = rbi;
    #1;
    coll = le && re && (la == ra);
    lc   = m_lv && (m_la == AW'(la));
    rc   = m_rv && (m_ra == AW'(ra));
    lwin = !(rc && !lc);
    bl   = ms && coll && !lwin;
    br   = ms && coll && lwin;
    ebl  = ms ? bl : !lbi;
    ebr  = ms ? br : !rbi;
    obs  = {l_busy_n, r_busy_n, l_wr_en, r_wr_en};
    if (!ms) tag = "R8";
    else if (!coll) tag = "R1";
    else if (lc || rc) tag = "R4";
    else tag = "R2,R7";
    check(tag, {2'b00, obs[3:2]}, {2'b00, !bl, !br});
    check(ms ? "R5" : "R8", {2'b00, obs[1:0]},
          {2'b00, le && lw && !ebl, re && rw && !ebr});
    check("R3", {3'b000, !(obs[3] || obs[2])}, 4'b0000);
    m_lv = le && !ebl; m_la = AW'(la);
    m_rv = re && !ebr; m_ra = AW'(ra);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] o, oa, ob;
    rst_n = 0; master_mode = 1;
    l_en = 0; l_addr = 0; l_wr_req = 0; l_busy_n_in = 1;
    r_en = 1; r_addr = 3'd5; r_wr_req = 1; r_busy_n_in = 1;
    m_lv = 0; m_rv = 0; m_la = '0; m_ra = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", {2'b00, l_busy_n, r_busy_n}, 4'b0011);
    // Right active through reset; after release a collision is a fresh tie.
    rst_n = 1; l_en = 1; l_addr = 3'd5;
    #1;
    check("R9", {2'b00, l_busy_n, r_busy_n}, 4'b0010);
    check("R9", {2'b00, l_wr_en, r_wr_en}, 4'b0000);
    m_lv = 1; m_la = 3'd5; m_rv = 0; m_ra = 3'd5;

    // R4 directed: right holds address 2, left arrives.
    step(1, 0, 0, 0, 1, 1, 2, 1, 1, o);
    step(1, 1, 2, 1, 1, 1, 2, 1, 1, o);
    check("R4", {2'b00, o[3:2]}, 4'b0001);
    step(1, 0, 0, 0, 1, 0, 0, 0, 1, o);

    // R6 directed: same fresh clash, swapped read/write.
    step(1, 1, 6, 0, 1, 1, 6, 1, 1, oa);
    step(1, 0, 0, 0, 1, 0, 0, 0, 1, o);
    step(1, 1, 6, 1, 1, 1, 6, 0, 1, ob);
    check("R6", {2'b00, oa[3:2]}, {2'b00, ob[3:2]});
    step(1, 0, 0, 0, 1, 0, 0, 0, 1, o);

    // Master sweep.
    for (int le = 0; le < 2; le++)
      for (int re = 0; re < 2; re++)
        for (int la = 0; la < 8; la++)
          for (int ra = 0; ra < 8; ra++)
            for (int w = 0; w < 4; w++)
              step(1, le[0], la, w[0], 1, re[0], ra, w[1], 1, o);

    // Slave sweep including inhibit inputs.
    for (int le = 0; le < 2; le++)
      for (int re = 0; re < 2; re++)
        for (int la = 0; la < 8; la++)
          for (int ra = 0; ra < 8; ra++)
            for (int w = 0; w < 16; w++)
              step(0, le[0], la, w[0], w[2], re[0], ra, w[1], w[3], o);

    // Back to master after slave history.
    for (int k = 0; k < 8; k++)
      step(1, 1, k, k[0], 1, 1, 7 - k, !k[0], 1, o);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule